// File: doc/BRIEF.md
# Two-Color Pixel-Stream Cursor Overlay

This block lays a 32 by 32 hardware cursor over a stream of palette-indexed pixels. Each incoming pixel carries its screen coordinates and an 8-bit base color index. The block decides whether the pixel shows the base color or one of two fixed overlay slots, 258 or 259, and emits a 9-bit palette index one clock later. The palette lookup, the frame store and the raster timing sit outside this block.

Software shapes the cursor through a small word-addressed register window. One word packs the cursor origin: the column in the upper half and the row in the lower half. Two banks of 32 words hold the cursor shape. Each row has a transparency word and a color-select word, and both are read most significant bit first from the cursor's left edge. A scratch word reads back with one status bit forced high. Every other offset reads as zero.

After reset the origin sits at 0xF000 in both axes, so no cursor pixel can appear until software places it.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is low, `out_valid` and `out_index` are 0. After reset the cursor origin is (0xF000, 0xF000), every pixel passes its base index through, and a read of offset 0x818 returns 0x0200_0000.
- R2: A write to offset 0x8FC loads the cursor column from data bits 31:16 and the cursor row from data bits 15:0.
- R3: A write to an offset from 0x900 through 0x97F loads transparency row (offset - 0x900) >> 2.
- R4: A write to an offset from 0x980 through 0x9FF loads color-select row (offset - 0x980) >> 2.
- R5: A pixel (x, y) is inside the cursor only when all of these hold: cy <= y < cy + 32, cx <= x < cx + 32 and cx < SCREEN_W. The comparisons use unwrapped 17-bit sums.
- R6: Within a row, bit 31 of the row word covers column cx and bit 0 covers column cx + 31.
- R7: Inside the cursor, where the transparency bit is 1, the output is 259 (9'h103) if the color-select bit is 1 and 258 (9'h102) otherwise.
- R8: Inside the cursor, where the transparency bit is 0, and everywhere outside the cursor, the output is the base index with bit 8 clear.
- R9: A pixel with x >= SCREEN_W never shows the cursor, and no pixel shows the cursor while cx >= SCREEN_W.
- R10: Offset 0x818 stores the written word and reads it back with bit 25 set. Every other offset reads 0. The read data is combinational on the address.
- R11: `out_valid` equals `pix_valid` one clock later. The outputs `out_x`, `out_y` and `out_index` belong to the pixel accepted on that edge. A pixel presented in the same cycle as a register write sees the register state from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 16 | Input pixel column |
| pix_y | input | 16 | Input pixel row |
| pix_index | input | 8 | Base palette index |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | 16 | Column of output pixel |
| out_y | output | 16 | Row of output pixel |
| out_index | output | 9 | Final palette index (base, 258 or 259) |

## Verification
The embedded assertions check, on every cycle, the properties that need no knowledge of the cursor shape:
- the one-cycle valid latency;
- base passthrough for columns beyond the screen edge or when the origin lies off screen;
- overlay codes always being 258 or 259;
- the packed origin load;
- the forced status bit on the scratch word.

Only the bench's scenarios can show that the correct row word and the correct bit within it are chosen for each pixel. Those scenarios are the full-window sweeps, the single-bit probes at both ends of a row, the last row, the right screen edge, and the cycle in which a write and a pixel coincide.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  localparam logic [11:0] OFF_MISC = 12'h818;
  localparam logic [11:0] OFF_POS  = 12'h8FC;
  localparam logic [11:0] OFF_MASK = 12'h900;
  localparam logic [11:0] OFF_BITS = 12'h980;

  localparam logic [8:0]  OVL_BG   = 9'd258;
  localparam logic [8:0]  OVL_FG   = 9'd259;

  localparam int unsigned MISC_FLAG_BIT = 25;
  localparam logic [15:0] PARK_COORD    = 16'hF000;

  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_BG   = 2'd1,
    SEL_FG   = 2'd2
  } pix_sel_e;

  // True when base <= p < base + len, evaluated without wrap-around.
  function automatic logic in_span(input logic [31:0] p,
                                   input logic [31:0] base,
                                   input logic [31:0] len);
    return (p >= base) && (p < base + len);
  endfunction

  // Final palette index for a selection and a base index.
  function automatic logic [8:0] pick_index(input pix_sel_e sel,
                                            input logic [7:0] base);
    case (sel)
      SEL_FG:  return OVL_FG;
      SEL_BG:  return OVL_BG;
      default: return {1'b0, base};
    endcase
  endfunction

endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int unsigned AW      = 12,
  parameter int unsigned DW      = 32,
  parameter int unsigned COORD_W = 16,
  parameter int unsigned CUR_N   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 wdata,
  output logic [DW-1:0]                 rdata,
  output logic [COORD_W-1:0]            cur_x,
  output logic [COORD_W-1:0]            cur_y,
  output logic [CUR_N-1:0][CUR_N-1:0]   mask_rows,
  output logic [CUR_N-1:0][CUR_N-1:0]   bit_rows
);

  localparam int unsigned RW       = $clog2(CUR_N);
  localparam int unsigned BANK_LEN = CUR_N * 4;
  localparam logic [RW-1:0] MASK_LO = OFF_MASK[RW+1:2];
  localparam logic [RW-1:0] BITS_LO = OFF_BITS[RW+1:2];

  logic          pos_sel, mask_sel, bits_sel, misc_sel;
  logic [RW-1:0] mask_row, bits_row;
  logic [DW-1:0] misc_q;

  assign pos_sel  = (addr == OFF_POS);
  assign misc_sel = (addr == OFF_MISC);
  assign mask_sel = in_span(32'(addr), 32'(OFF_MASK), 32'(BANK_LEN));
  assign bits_sel = in_span(32'(addr), 32'(OFF_BITS), 32'(BANK_LEN));
  assign mask_row = addr[RW+1:2] - MASK_LO;
  assign bits_row = addr[RW+1:2] - BITS_LO;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_x  <= COORD_W'(PARK_COORD);
      cur_y  <= COORD_W'(PARK_COORD);
      misc_q <= '0;
    end else if (wr_en) begin
      if (pos_sel) begin
        cur_x <= wdata[DW-1 -: COORD_W];
        cur_y <= wdata[COORD_W-1:0];
      end
      if (misc_sel) misc_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_rows <= '0;
      bit_rows  <= '0;
    end else if (wr_en) begin
      for (int r = 0; r < CUR_N; r++) begin
        if (mask_sel && mask_row == RW'(r)) mask_rows[r] <= wdata[CUR_N-1:0];
        if (bits_sel && bits_row == RW'(r)) bit_rows[r]  <= wdata[CUR_N-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (misc_sel) begin
      rdata = misc_q;
      rdata[MISC_FLAG_BIT] = 1'b1;
    end
  end

  assert_pos_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFF_POS) |=>
      (cur_x == $past(wdata[DW-1 -: COORD_W]) && cur_y == $past(wdata[COORD_W-1:0])));

  assert_misc_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFF_MISC) |-> rdata[MISC_FLAG_BIT]);

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != OFF_MISC) |-> (rdata == '0));

endmodule

// File: rtl/cursor_hit.sv
module cursor_hit
  import cursor_pkg::*;
#(
  parameter int unsigned COORD_W  = 16,
  parameter int unsigned CUR_N    = 32,
  parameter int unsigned SCREEN_W = 1024
) (
  input  logic [COORD_W-1:0]          pix_x,
  input  logic [COORD_W-1:0]          pix_y,
  input  logic [COORD_W-1:0]          cur_x,
  input  logic [COORD_W-1:0]          cur_y,
  input  logic [CUR_N-1:0][CUR_N-1:0] mask_rows,
  input  logic [CUR_N-1:0][CUR_N-1:0] bit_rows,
  output logic                        in_window,
  output pix_sel_e                    sel
);

  localparam int unsigned RW = $clog2(CUR_N);

  logic          in_x, in_y, on_screen;
  logic [RW-1:0] col, row, bit_pos;
  logic          mask_bit, color_bit;

  assign on_screen = (32'(cur_x) < SCREEN_W) && (32'(pix_x) < SCREEN_W);
  assign in_x      = in_span(32'(pix_x), 32'(cur_x), 32'(CUR_N));
  assign in_y      = in_span(32'(pix_y), 32'(cur_y), 32'(CUR_N));
  assign in_window = in_x && in_y && on_screen;

  // Offsets inside the window only need their low bits.
  assign col     = pix_x[RW-1:0] - cur_x[RW-1:0];
  assign row     = pix_y[RW-1:0] - cur_y[RW-1:0];
  assign bit_pos = RW'(CUR_N - 1) - col;

  assign mask_bit  = mask_rows[row][bit_pos];
  assign color_bit = bit_rows[row][bit_pos];

  always_comb begin
    sel = SEL_BASE;
    if (in_window && mask_bit) sel = color_bit ? SEL_FG : SEL_BG;
  end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int unsigned SCREEN_W = 1024,
  parameter int unsigned CUR_N    = 32,
  parameter int unsigned COORD_W  = 16,
  parameter int unsigned IDX_W    = 8,
  parameter int unsigned AW       = 12,
  parameter int unsigned DW       = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  input  logic               pix_valid,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [IDX_W-1:0]   pix_index,
  output logic               out_valid,
  output logic [COORD_W-1:0] out_x,
  output logic [COORD_W-1:0] out_y,
  output logic [IDX_W:0]     out_index
);

  logic [COORD_W-1:0]          cur_x, cur_y;
  logic [CUR_N-1:0][CUR_N-1:0] mask_rows, bit_rows;
  logic                        in_window;
  pix_sel_e                    hit_sel;

  cursor_regs #(
    .AW(AW), .DW(DW), .COORD_W(COORD_W), .CUR_N(CUR_N)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cur_x(cur_x), .cur_y(cur_y),
    .mask_rows(mask_rows), .bit_rows(bit_rows)
  );

  cursor_hit #(
    .COORD_W(COORD_W), .CUR_N(CUR_N), .SCREEN_W(SCREEN_W)
  ) u_hit (
    .pix_x(pix_x), .pix_y(pix_y), .cur_x(cur_x), .cur_y(cur_y),
    .mask_rows(mask_rows), .bit_rows(bit_rows),
    .in_window(in_window), .sel(hit_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_x     <= '0;
      out_y     <= '0;
      out_index <= '0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid) begin
        out_x     <= pix_x;
        out_y     <= pix_y;
        out_index <= pick_index(hit_sel, pix_index);
      end
    end
  end

  assert_valid_lat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);

  assert_idle_lat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);

  assert_edge_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && 32'(pix_x) >= SCREEN_W) |=> (out_index == {1'b0, $past(pix_index)}));

  assert_parked_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && 32'(cur_x) >= SCREEN_W) |=> (out_index == {1'b0, $past(pix_index)}));

  assert_outside_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !in_window) |=> (out_index == {1'b0, $past(pix_index)}));

  assert_overlay_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_index[IDX_W] |-> (out_index == OVL_BG || out_index == OVL_FG));

endmodule

// File: tb/tb_cursor_overlay.sv
module tb_cursor_overlay;

  localparam int CLK_PERIOD = 10;
  localparam int SCREEN     = 1024;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        pix_valid;
  logic [15:0] pix_x, pix_y;
  logic [7:0]  pix_index;
  logic        out_valid;
  logic [15:0] out_x, out_y;
  logic [8:0]  out_index;

  always #(CLK_PERIOD/2) clk = ~clk;

  cursor_overlay #(.SCREEN_W(SCREEN)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid(pix_valid),
    .pix_x(pix_x), .pix_y(pix_y), .pix_index(pix_index),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_index(out_index)
  );

  int          n_checks = 0;
  int          n_fails  = 0;
  logic [31:0] m_mask [32];
  logic [31:0] m_bits [32];
  int          m_cx, m_cy;
  logic [31:0] m_misc;

  task automatic check(string tag, string what, longint act, longint exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int model_index(int x, int y, int idx);
    int col, row;
    if (y < m_cy || y >= m_cy + 32) return idx;
    if (x < m_cx || x >= m_cx + 32) return idx;
    if (m_cx >= SCREEN || x >= SCREEN) return idx;
    col = x - m_cx;
    row = y - m_cy;
    if (m_mask[row][31 - col] == 1'b0) return idx;
    return m_bits[row][31 - col] ? 259 : 258;
  endfunction

  function automatic longint model_read(int a);
    if (a == 'h818) return longint'(m_misc | 32'h0200_0000);
    return 0;
  endfunction

  // One clock: predict from pre-edge state, then apply the write to the model.
  task automatic step(string tag);
    logic        e_valid;
    int          e_idx, e_x, e_y;
    logic        w;
    int          a;
    logic [31:0] d;
    e_valid = pix_valid;
    e_x     = pix_x;
    e_y     = pix_y;
    e_idx   = model_index(pix_x, pix_y, pix_index);
    w = reg_wr; a = reg_addr; d = reg_wdata;
    @(posedge clk);
    #1;
    if (w) begin
      if (a == 'h8FC) begin m_cx = d[31:16]; m_cy = d[15:0]; end
      if (a >= 'h900 && a < 'h980) m_mask[(a - 'h900) >> 2] = d;
      if (a >= 'h980 && a < 'hA00) m_bits[(a - 'h980) >> 2] = d;
      if (a == 'h818) m_misc = d;
    end
    check(tag, "out_valid", out_valid, e_valid);
    if (e_valid) begin
      check(tag, "out_index", out_index, e_idx);
      check(tag, "out_x", out_x, e_x);
      check(tag, "out_y", out_y, e_y);
    end
  endtask

  task automatic reg_write(int a, logic [31:0] d, string tag);
    reg_wr = 1'b1; reg_addr = 12'(a); reg_wdata = d;
    step(tag);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(int a, string tag);
    reg_addr = 12'(a);
    #1;
    check(tag, "reg_rdata", reg_rdata, model_read(a));
  endtask

  // Tag follows the model's own classification of the pixel.
  task automatic pixel(int x, int y, int idx, string tag);
    string t;
    int e;
    t = tag;
    if (t == "") begin
      e = model_index(x, y, idx);
      t = (e >= 258) ? "R7" : "R8";
    end
    pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y); pix_index = 8'(idx);
    step(t);
    pix_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fails++;
    $display("FAIL watchdog R11 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    pix_valid = 1'b0; pix_x = '0; pix_y = '0; pix_index = '0;
    for (int r = 0; r < 32; r++) begin m_mask[r] = '0; m_bits[r] = '0; end
    m_cx = 'hF000; m_cy = 'hF000; m_misc = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "out_valid in reset", out_valid, 0);
    check("R1", "out_index in reset", out_index, 0);
    rst_n = 1'b1;
    reg_read('h818, "R1");

    // R1: parked cursor passes every pixel through.
    pixel(5, 5, 8'h3C, "R1");
    pixel('hF005, 'hF005, 8'h77, "R1");

    // R10: scratch word and unmapped offsets.
    reg_write('h818, 32'h1234_5678, "R10");
    reg_read('h818, "R10");
    reg_read('h81C, "R10");
    reg_read('h8FC, "R10");
    reg_read('h900, "R10");

    // R3, R4: load all shape rows.
    for (int r = 0; r < 32; r++) begin
      reg_write('h900 + 4*r, (32'h8000_0001 | (32'h00FF_FF00 >> r)) ^ (32'h1 << r), "R3");
      reg_write('h980 + 4*r, 32'hAAAA_5555 ^ (32'(r) << 7), "R4");
    end

    // R2: packed origin.
    reg_write('h8FC, 32'h000A_0014, "R2");
    pixel(10, 20, 8'h11, "R2");
    pixel(9, 20, 8'h12, "R5");
    pixel(10, 19, 8'h13, "R5");
    pixel(41, 51, 8'h14, "R5");
    pixel(42, 51, 8'h15, "R5");
    pixel(41, 52, 8'h16, "R5");

    // Full sweep over and around the window.
    for (int y = 18; y < 54; y++)
      for (int x = 8; x < 44; x++)
        pixel(x, y, (x + y) & 255, "");

    // R6: single-bit probes at both ends of row 0.
    reg_write('h900, 32'h8000_0000, "R6");
    reg_write('h980, 32'h8000_0000, "R6");
    pixel(10, 20, 8'h21, "R6");
    pixel(11, 20, 8'h22, "R6");
    reg_write('h900, 32'h0000_0001, "R6");
    reg_write('h980, 32'h0000_0000, "R6");
    pixel(41, 20, 8'h23, "R6");
    pixel(10, 20, 8'h24, "R6");

    // R4: last row, last word of each bank.
    reg_write('h97C, 32'hFFFF_FFFF, "R3");
    reg_write('h9FC, 32'h0F0F_0F0F, "R4");
    for (int x = 10; x < 42; x++) pixel(x, 51, x, "R4");

    // R9: right screen edge and off-screen origin.
    reg_write('h8FC, {16'd1010, 16'd5}, "R9");
    for (int x = 1008; x < 1045; x++) begin
      pixel(x, 5, 8'h40, "R9");
      pixel(x, 36, 8'h41, "R9");
    end
    reg_write('h8FC, {16'd1023, 16'd0}, "R9");
    pixel(1023, 0, 8'h42, "R9");
    pixel(1024, 0, 8'h43, "R9");
    reg_write('h8FC, {16'd1024, 16'd0}, "R9");
    for (int x = 1020; x < 1060; x++) pixel(x, 3, 8'h44, "R9");

    // R5: window at row 0xFFF0 spans unwrapped past 0xFFFF.
    reg_write('h8FC, {16'd100, 16'hFFF0}, "R5");
    pixel(100, 'hFFF0, 8'h50, "R5");
    pixel(100, 'hFFFF, 8'h51, "R5");
    pixel(100, 0, 8'h52, "R5");

    // R11: write and pixel in the same cycle, then idle gaps.
    reg_wr = 1'b1; reg_addr = 12'h8FC; reg_wdata = {16'd200, 16'd200};
    pix_valid = 1'b1; pix_x = 16'd100; pix_y = 16'hFFF0; pix_index = 8'h60;
    step("R11");
    reg_wr = 1'b0;
    pix_x = 16'd200; pix_y = 16'd200; pix_index = 8'h61;
    step("R11");
    pix_valid = 1'b0;
    step("R11");
    step("R11");
    pixel(231, 231, 8'h62, "R11");
    step("R11");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule